// File: doc/BRIEF.md
# Log-approximate single-precision multiplier

This block multiplies two IEEE-754 single-precision numbers. The exact significand multiplier is replaced by a logarithm-style approximation. Each operand is normal, so its significand always has the form 1.f with the leading one in a fixed place. No leading-one search and no alignment shifter are needed. The product (1+a)(1+b) is estimated from the sum of the two fractions. When a+b stays below one, the estimate is 1+a+b. When a+b reaches one or more, the estimate is 2(a+b) and the exponent goes up by one. The sign is the XOR of the operand signs. The exponents are added and the bias is subtracted once.

A design-time parameter, `TRUNC_BITS`, removes the lowest fraction bits of both operands before the addition. This lets an integrator trade accuracy for a narrower adder. Zero, infinity and NaN operands skip the approximate path and follow the IEEE special-case rules. Subnormal inputs are treated as zero, and results that would be too small are flushed to zero. The fraction sum fits the result field exactly, so round-to-nearest-even never changes the value. Operands enter with a valid strobe. Each result appears exactly two clock cycles later with its own valid strobe.

Top module: `approx_fp_mul`

## Requirements
- R1: `res_valid` is high exactly two rising clock edges after each edge on which `in_valid` was high. Results come out in the same order as their operands went in.
- R2: Every result other than the canonical NaN has a sign bit equal to the XOR of the two operand sign bits.
- R3: For two normal operands (exponent field 1..254), call the masked fractions a and b (23 bits each). When a+b < 2^23, the result fraction is a+b and the result exponent field is ea+eb-127.
- R4: For two normal operands with a+b >= 2^23, the result fraction is a+b-2^23 and the result exponent field is ea+eb-126.
- R5: The lowest `TRUNC_BITS` fraction bits of each operand are ignored. Changing them does not change the result, and every normal result has those low fraction bits equal to zero.
- R6: An operand whose exponent field is 0 is treated as zero, whether it is zero or subnormal. Zero times any finite value or zero gives a signed zero, `{sign, 31'b0}`.
- R7: Infinity (exponent field 255, fraction 0) times any non-zero, non-NaN value gives a signed infinity, `{sign, 8'hFF, 23'b0}`.
- R8: A NaN operand (exponent field 255, non-zero fraction), or zero times infinity in either order, gives the canonical NaN `32'h7FC0_0000`.
- R9: When the final biased exponent is 255 or more, the result saturates to signed infinity.
- R10: When the final biased exponent is 0 or less, the result flushes to signed zero. No subnormal result is ever produced.
- R11: While `rst` is high, and on the first clock after it, `res_valid` and `res` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are valid this cycle |
| op_a | input | 32 | First operand, single-precision |
| op_b | input | 32 | Second operand, single-precision |
| res_valid | output | 1 | `res` holds a product this cycle |
| res | output | 32 | Approximate product, single-precision |

## Verification
The datapath keeps no state between operations. A fault shows up at the ports on the exact result word, two cycles after the operand pair that triggers it. A wrong carry decision shows up as an exponent off by one together with a fraction shifted by 2^23. A wrong truncation mask shows up as non-zero low fraction bits. A wrong class decode shows up as a finite word where infinity, zero or NaN belongs. A broken valid pipe shows up as a missing or extra result strobe, or as results falling out of step with the queue of expected words.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int XW     = EXP_W + 2;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpm_cls_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
    fpm_cls_e          cls;
  } fpm_opnd_t;

  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fpm_opnd_t         opnd
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;

  assign e = word[WORD_W-2 -: EXP_W];
  assign f = word[FRAC_W-1:0];

  always_comb begin
    opnd.sign = word[WORD_W-1];
    opnd.exp  = e;
    opnd.frac = f;
    if (e == '0)
      opnd.cls = CLS_ZERO;
    else if (e == '1)
      opnd.cls = (f != '0) ? CLS_NAN : CLS_INF;
    else
      opnd.cls = CLS_NORM;
  end
endmodule

// File: rtl/fpm_log_mant.sv
module fpm_log_mant #(
  parameter int FW         = 23,
  parameter int TRUNC_BITS = 4
) (
  input  logic [FW-1:0] frac_a,
  input  logic [FW-1:0] frac_b,
  output logic [FW-1:0] frac_sum,
  output logic          carry
);
  logic [FW-1:0] ta, tb;

  generate
    if (TRUNC_BITS == 0) begin : g_full
      assign ta = frac_a;
      assign tb = frac_b;
    end else begin : g_trunc
      assign ta = {frac_a[FW-1:TRUNC_BITS], {TRUNC_BITS{1'b0}}};
      assign tb = {frac_b[FW-1:TRUNC_BITS], {TRUNC_BITS{1'b0}}};
    end
  endgenerate

  // log-domain product: fraction sum, carry selects the 2(a+b) branch
  assign {carry, frac_sum} = {1'b0, ta} + {1'b0, tb};
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fpm_pkg::*;
(
  input  logic                 sign,
  input  fpm_cls_e             cls_a,
  input  fpm_cls_e             cls_b,
  input  logic signed [XW-1:0] exp_base,
  input  logic                 carry,
  input  logic [FRAC_W-1:0]    frac,
  output logic [WORD_W-1:0]    word
);
  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);

  logic signed [XW-1:0] exp_fin;
  logic is_nan, is_inf, is_zero;

  assign exp_fin = exp_base + $signed({{(XW-1){1'b0}}, carry});

  assign is_nan  = (cls_a == CLS_NAN) || (cls_b == CLS_NAN) ||
                   (cls_a == CLS_INF && cls_b == CLS_ZERO) ||
                   (cls_a == CLS_ZERO && cls_b == CLS_INF);
  assign is_inf  = (cls_a == CLS_INF) || (cls_b == CLS_INF);
  assign is_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);

  always_comb begin
    if (is_nan)
      word = QNAN_WORD;
    else if (is_inf || exp_fin >= EXP_TOP)
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (is_zero || exp_fin <= $signed(XW'(0)))
      word = {sign, {(WORD_W-1){1'b0}}};
    else
      word = {sign, exp_fin[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/approx_fp_mul.sv
module approx_fp_mul
  import fpm_pkg::*;
#(
  parameter int TRUNC_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              res_valid,
  output logic [WORD_W-1:0] res
);
  localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);

  logic [WORD_W-1:0] words [2];
  fpm_opnd_t         opnd  [2];

  assign words[0] = op_a;
  assign words[1] = op_b;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_unpack
      fpm_unpack u_unpack (.word(words[g]), .opnd(opnd[g]));
    end
  endgenerate

  logic [FRAC_W-1:0] sum_c;
  logic              carry_c;

  fpm_log_mant #(.FW(FRAC_W), .TRUNC_BITS(TRUNC_BITS)) u_mant (
    .frac_a  (opnd[0].frac),
    .frac_b  (opnd[1].frac),
    .frac_sum(sum_c),
    .carry   (carry_c)
  );

  // stage 1 registers
  logic                 s1_valid, s1_sign, s1_carry;
  fpm_cls_e             s1_cls_a, s1_cls_b;
  logic signed [XW-1:0] s1_exp;
  logic [FRAC_W-1:0]    s1_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_carry <= 1'b0;
      s1_cls_a <= CLS_ZERO;
      s1_cls_b <= CLS_ZERO;
      s1_exp   <= '0;
      s1_frac  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sign  <= opnd[0].sign ^ opnd[1].sign;
      s1_carry <= carry_c;
      s1_cls_a <= opnd[0].cls;
      s1_cls_b <= opnd[1].cls;
      s1_exp   <= $signed({2'b00, opnd[0].exp}) + $signed({2'b00, opnd[1].exp}) - BIAS_S;
      s1_frac  <= sum_c;
    end
  end

  logic [WORD_W-1:0] packed_c;

  fpm_pack u_pack (
    .sign    (s1_sign),
    .cls_a   (s1_cls_a),
    .cls_b   (s1_cls_b),
    .exp_base(s1_exp),
    .carry   (s1_carry),
    .frac    (s1_frac),
    .word    (packed_c)
  );

  // stage 2 registers (outputs)
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= s1_valid;
      res       <= packed_c;
    end
  end

  // R1
  out_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 res_valid);

  // R8
  nan_in_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a[WORD_W-2 -: EXP_W] == '1 && op_a[FRAC_W-1:0] != '0)
      |=> ##1 (res == QNAN_WORD));

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res != QNAN_WORD) |-> res[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1], 2));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res[WORD_W-2 -: EXP_W] == '1) |-> (res[FRAC_W-1:0] == '0 || res == QNAN_WORD));

  // R10
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res[WORD_W-2 -: EXP_W] == '0) |-> res[FRAC_W-1:0] == '0);

  generate
    if (TRUNC_BITS > 0) begin : g_trunc_chk
      // R5
      trunc_low_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res[WORD_W-2 -: EXP_W] != '1) |-> res[TRUNC_BITS-1:0] == '0);
    end
  endgenerate
endmodule

// File: tb/approx_fp_mul_tb_top.sv
module approx_fp_mul_tb_top;
  localparam int TB_TRUNC = 4;
  localparam logic [22:0] TB_MASK = ~((23'd1 << TB_TRUNC) - 23'd1);
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic res_valid;
  logic [31:0] res;

  always #10 clk = ~clk;

  approx_fp_mul #(.TRUNC_BITS(TB_TRUNC)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res(res)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b);
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    logic [23:0] sum;
    logic s;
    bit nan_a, nan_b, inf_a, inf_b, z_a, z_b;
    int e;
    ea = a[30:23]; eb = b[30:23];
    fa = a[22:0];  fb = b[22:0];
    s = a[31] ^ b[31];
    nan_a = (ea == 8'hFF) && (fa != 0);
    nan_b = (eb == 8'hFF) && (fb != 0);
    inf_a = (ea == 8'hFF) && (fa == 0);
    inf_b = (eb == 8'hFF) && (fb == 0);
    z_a = (ea == 0);
    z_b = (eb == 0);
    if (nan_a || nan_b || (inf_a && z_b) || (z_a && inf_b)) return QNAN;
    if (inf_a || inf_b) return {s, 8'hFF, 23'd0};
    if (z_a || z_b) return {s, 31'd0};
    sum = {1'b0, fa & TB_MASK} + {1'b0, fb & TB_MASK};
    e = int'(ea) + int'(eb) - 127 + int'(sum[23]);
    if (e >= 255) return {s, 8'hFF, 23'd0};
    if (e <= 0) return {s, 31'd0};
    return {s, 8'(e), sum[22:0]};
  endfunction

  task automatic send(logic [31:0] a, logic [31:0] b, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    it.a = a; it.b = b; it.exp = model(a, b); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = '0;
      op_b = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_fails++;
        $display("FAIL R1 unexpected result actual=%08h expected=none", res);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, res, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid in reset", {31'd0, res_valid}, 32'd0);
    check("R11 result in reset", res, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 valid after reset", {31'd0, res_valid}, 32'd0);

    // R1: exact two-cycle latency of a lone operation
    send(32'h3FA0_0000, 32'h3FA0_0000, "R3 1.25*1.25");
    idle(1);
    check("R1 valid one cycle after", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    check("R1 valid two cycles after", {31'd0, res_valid}, 32'd1);
    idle(2);

    // back-to-back normal operands
    send(32'h3FC0_0000, 32'h3FC0_0000, "R4 1.5*1.5 carry");
    send(32'h4000_0000, 32'h4040_0000, "R3 2*3");
    send(32'hBFC0_0000, 32'h4000_0000, "R2 -1.5*2");
    send(32'hC040_0000, 32'hC0A0_0000, "R2 -3*-5");
    send(32'h3F70_0000, 32'h4120_0000, "R4 0.9375*10");
    send(32'h3F80_000F, 32'h3F80_0001, "R5 low bits ignored");
    send(32'h3F80_0000, 32'h3F80_0000, "R5 reference 1*1");
    idle(1);
    send(32'h3FD5_5557, 32'h3F8A_AAA9, "R5 low fraction zero");

    // specials
    send(32'h0000_0000, 32'h40A0_0000, "R6 zero*5");
    send(32'h8000_0000, 32'h4040_0000, "R6 -0*3");
    send(32'h0000_0001, 32'h4000_0000, "R6 subnormal*2");
    send(32'h7F80_0000, 32'hC000_0000, "R7 inf*-2");
    send(32'hFF80_0000, 32'hFF80_0000, "R7 -inf*-inf");
    send(32'h7FC0_1234, 32'h3F80_0000, "R8 nan*1");
    send(32'h3F80_0000, 32'hFF80_0001, "R8 1*nan");
    send(32'h0000_0000, 32'hFF80_0000, "R8 zero*inf");
    send(32'h7F80_0000, 32'h8000_0000, "R8 inf*-zero");

    // exponent boundaries
    send(32'h7F00_0000, 32'h7F00_0000, "R9 overflow");
    send(32'h7F00_0000, 32'h4000_0000, "R9 exp exactly 255");
    send(32'h7F40_0000, 32'h3FC0_0000, "R9 carry into 255");
    send(32'h7F00_0000, 32'h3F80_0000, "R3 exp 254 kept");
    send(32'h0080_0000, 32'h0080_0000, "R10 underflow");
    send(32'h8080_0000, 32'h3F80_0000, "R10 exp exactly 1 kept");
    send(32'h0080_0000, 32'h3F00_0000, "R10 exp exactly 0");
    send(32'h00C0_0000, 32'h3F40_0000, "R10 carry lifts to 1");
    idle(4);

    check("R1 all results returned", sb_q.size(), 0);
    finish_run();
  end
endmodule